// File: doc/BRIEF.md
# Register-Pair Arithmetic Unit

This unit executes the 16-bit arithmetic operations of a small 8-bit processor that keeps four register pairs (BC, DE, HL and the stack pointer SP) and a four-bit flag register. Each cycle in which `issue_i` is high, the unit takes a one-byte opcode and an optional immediate byte, together with the current pair values and flags. One clock edge later it presents a registered result: the destination pair and its new value, new flag values, the write strobes for both, and the instruction length in bytes so that the program counter can advance.

Four operations are supported. A pair can be incremented or decremented, a pair can be added into HL, and a signed immediate can be added to SP. Each operation has its own flag rule. Opcodes outside this set are reported as illegal and cause no writes. Instruction fetch, memory and the 8-bit ALU are outside the unit.

Top module: `rp_arith16`

## Requirements
- R1: While reset is asserted, and afterwards until the first issue, every output is zero.
- R2: An issue in one cycle produces `done_o` high in the next cycle only. `pair_we_o` and `flag_we_o` are never high unless `done_o` is high.
- R3: Opcodes 0x03, 0x13, 0x23 and 0x33 increment a pair modulo 2^16, with a length of 1. Opcode bits 5:4 select the pair, and that code appears on `pair_sel_o`: 0 = BC, 1 = DE, 2 = HL, 3 = SP.
- R4: Opcodes 0x0B, 0x1B, 0x2B and 0x3B decrement the pair chosen by bits 5:4, wrapping modulo 2^16 (0x0000 becomes 0xFFFF), with a length of 1.
- R5: Increment and decrement keep `flag_we_o` low, and `flags_o` equals the `flags_i` value that was issued. Flag bits are [3] = Z, [2] = N, [1] = H, [0] = C.
- R6: Opcodes 0x09, 0x19, 0x29 and 0x39 add the pair chosen by bits 5:4 to HL modulo 2^16. The sum is written to HL (select 2) with a length of 1.
- R7: The add into HL writes flags as follows: Z is kept from `flags_i`, N is 0, H is the carry out of bit 11 and C is the carry out of bit 15.
- R8: Opcode 0xE8 sign-extends `imm_i` to 16 bits and adds it to SP. The sum is written to SP (select 3) with a length of 2.
- R9: Opcode 0xE8 writes Z = 0 and N = 0. H is the carry out of bit 3 and C is the carry out of bit 7 of the unsigned sum SP[7:0] + `imm_i`.
- R10: Any other opcode drives `illegal_o` high together with `done_o`, keeps both write enables low, and reports a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Execute the presented opcode this cycle |
| opcode_i | input | 8 | Operation byte |
| imm_i | input | 8 | Immediate byte for the SP add |
| bc_i | input | 16 | Current BC pair |
| de_i | input | 16 | Current DE pair |
| hl_i | input | 16 | Current HL pair |
| sp_i | input | 16 | Current stack pointer |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| done_o | output | 1 | Result valid, one cycle after issue |
| illegal_o | output | 1 | Issued opcode was not recognised |
| pair_we_o | output | 1 | Write strobe for the destination pair |
| pair_sel_o | output | 2 | Destination pair code |
| pair_data_o | output | 16 | New destination pair value |
| flag_we_o | output | 1 | Write strobe for the flag register |
| flags_o | output | 4 | New flags {Z,N,H,C} |
| len_o | output | 2 | Instruction length in bytes |

## Verification
The add into HL is driven with operand pairs chosen so that the carries out of bit 11 and bit 15 appear alone, together, and not at all. This separates a half-carry taken from the wrong bit from a full-carry error. The SP add uses both positive immediates and immediates with bit 7 set, which exposes a missing sign extension, and it also uses low bytes that do and do not carry out of bits 3 and 7. Increments and decrements at 0x0000 and 0xFFFF check the wraparound. Random flag inputs show whether flags are kept or overwritten, and random opcode bytes reach the illegal path.

// File: rtl/rp_arith16_pkg.sv
package rp_arith16_pkg;

   typedef enum logic [2:0] {
      OPK_NONE,
      OPK_INC,
      OPK_DEC,
      OPK_ADD_HL,
      OPK_ADD_SP
   } op_kind_t;

   localparam logic [1:0] PAIR_BC = 2'd0;
   localparam logic [1:0] PAIR_DE = 2'd1;
   localparam logic [1:0] PAIR_HL = 2'd2;
   localparam logic [1:0] PAIR_SP = 2'd3;

   localparam int FLG_Z = 3;
   localparam int FLG_N = 2;
   localparam int FLG_H = 1;
   localparam int FLG_C = 0;

   localparam logic [7:0] OPC_ADD_SP = 8'hE8;

endpackage

// File: rtl/rp_decode.sv
module rp_decode
   import rp_arith16_pkg::*;
(
   input  logic [7:0] opcode_i,
   output op_kind_t   kind_o,
   output logic [1:0] a_sel_o,
   output logic [1:0] b_sel_o,
   output logic [1:0] dst_sel_o,
   output logic [1:0] len_o
);

   logic [1:0] field;
   assign field = opcode_i[5:4];

   always_comb begin
      kind_o    = OPK_NONE;
      a_sel_o   = field;
      b_sel_o   = field;
      dst_sel_o = field;
      len_o     = 2'd1;
      if (opcode_i == OPC_ADD_SP) begin
         kind_o    = OPK_ADD_SP;
         a_sel_o   = PAIR_SP;
         dst_sel_o = PAIR_SP;
         len_o     = 2'd2;
      end else if (opcode_i[7:6] == 2'b00) begin
         unique case (opcode_i[3:0])
            4'h3: kind_o = OPK_INC;
            4'hB: kind_o = OPK_DEC;
            4'h9: begin
               kind_o    = OPK_ADD_HL;
               a_sel_o   = PAIR_HL;
               dst_sel_o = PAIR_HL;
            end
            default: kind_o = OPK_NONE;
         endcase
      end
   end

endmodule

// File: rtl/rp_datapath.sv
module rp_datapath
   import rp_arith16_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit SIGN_EXT_IMM = 1'b1
) (
   input  op_kind_t          kind_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [7:0]        imm_i,
   input  logic [3:0]        flags_i,
   output logic [DATA_W-1:0] result_o,
   output logic [3:0]        flags_o,
   output logic              flag_wr_o
);

   localparam int HALF_W = DATA_W - 4;

   logic [DATA_W-1:0] imm_ext;

   generate
      if (SIGN_EXT_IMM) begin : g_sext
         assign imm_ext = {{(DATA_W-8){imm_i[7]}}, imm_i};
      end else begin : g_zext
         assign imm_ext = {{(DATA_W-8){1'b0}}, imm_i};
      end
   endgenerate

   logic [DATA_W:0]   pair_sum;
   logic [HALF_W:0]   pair_half;
   logic [DATA_W-1:0] sp_sum;
   logic [8:0]        low_sum;
   logic [4:0]        nib_sum;

   assign pair_sum  = {1'b0, a_i} + {1'b0, b_i};
   assign pair_half = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_i[HALF_W-1:0]};
   assign sp_sum    = a_i + imm_ext;
   assign low_sum   = {1'b0, a_i[7:0]} + {1'b0, imm_i};
   assign nib_sum   = {1'b0, a_i[3:0]} + {1'b0, imm_i[3:0]};

   always_comb begin
      result_o  = a_i;
      flags_o   = flags_i;
      flag_wr_o = 1'b0;
      unique case (kind_i)
         OPK_INC: result_o = a_i + 1'b1;
         OPK_DEC: result_o = a_i - 1'b1;
         OPK_ADD_HL: begin
            result_o       = pair_sum[DATA_W-1:0];
            flags_o[FLG_N] = 1'b0;
            flags_o[FLG_H] = pair_half[HALF_W];
            flags_o[FLG_C] = pair_sum[DATA_W];
            flag_wr_o      = 1'b1;
         end
         OPK_ADD_SP: begin
            result_o       = sp_sum;
            flags_o[FLG_Z] = 1'b0;
            flags_o[FLG_N] = 1'b0;
            flags_o[FLG_H] = nib_sum[4];
            flags_o[FLG_C] = low_sum[8];
            flag_wr_o      = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/rp_arith16.sv
module rp_arith16
   import rp_arith16_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit SIGN_EXT_IMM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [7:0]        opcode_i,
   input  logic [7:0]        imm_i,
   input  logic [DATA_W-1:0] bc_i,
   input  logic [DATA_W-1:0] de_i,
   input  logic [DATA_W-1:0] hl_i,
   input  logic [DATA_W-1:0] sp_i,
   input  logic [3:0]        flags_i,
   output logic              done_o,
   output logic              illegal_o,
   output logic              pair_we_o,
   output logic [1:0]        pair_sel_o,
   output logic [DATA_W-1:0] pair_data_o,
   output logic              flag_we_o,
   output logic [3:0]        flags_o,
   output logic [1:0]        len_o
);

   localparam int NUM_PAIRS = 4;

   generate
      if (DATA_W < 12) begin : g_bad_width
         $error("rp_arith16: DATA_W must be at least 12");
      end
   endgenerate

   op_kind_t          kind;
   logic [1:0]        a_sel, b_sel, dst_sel, len_nxt;
   logic [DATA_W-1:0] pairs [NUM_PAIRS];
   logic [DATA_W-1:0] opa, opb, result;
   logic [3:0]        flags_nxt;
   logic              flag_wr;

   always_comb begin
      pairs[PAIR_BC] = bc_i;
      pairs[PAIR_DE] = de_i;
      pairs[PAIR_HL] = hl_i;
      pairs[PAIR_SP] = sp_i;
      opa = pairs[a_sel];
      opb = pairs[b_sel];
   end

   rp_decode u_dec (
      .opcode_i  (opcode_i),
      .kind_o    (kind),
      .a_sel_o   (a_sel),
      .b_sel_o   (b_sel),
      .dst_sel_o (dst_sel),
      .len_o     (len_nxt)
   );

   rp_datapath #(
      .DATA_W       (DATA_W),
      .SIGN_EXT_IMM (SIGN_EXT_IMM)
   ) u_dp (
      .kind_i    (kind),
      .a_i       (opa),
      .b_i       (opb),
      .imm_i     (imm_i),
      .flags_i   (flags_i),
      .result_o  (result),
      .flags_o   (flags_nxt),
      .flag_wr_o (flag_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o      <= 1'b0;
         illegal_o   <= 1'b0;
         pair_we_o   <= 1'b0;
         pair_sel_o  <= '0;
         pair_data_o <= '0;
         flag_we_o   <= 1'b0;
         flags_o     <= '0;
         len_o       <= '0;
      end else if (issue_i) begin
         done_o      <= 1'b1;
         illegal_o   <= (kind == OPK_NONE);
         pair_we_o   <= (kind != OPK_NONE);
         pair_sel_o  <= dst_sel;
         pair_data_o <= result;
         flag_we_o   <= flag_wr;
         flags_o     <= flags_nxt;
         len_o       <= len_nxt;
      end else begin
         done_o    <= 1'b0;
         illegal_o <= 1'b0;
         pair_we_o <= 1'b0;
         flag_we_o <= 1'b0;
      end
   end

   a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |=> done_o);
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> !done_o);
   a_r2_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_we_o || flag_we_o) |-> done_o);
   a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (!pair_we_o && !flag_we_o && len_o == 2'd1));
   a_r8_len_two_sp: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && len_o == 2'd2) |-> (pair_sel_o == PAIR_SP && pair_we_o));
   a_r9_spflags_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_o && pair_sel_o == PAIR_SP) |-> (flags_o[FLG_Z] == 1'b0 && flags_o[FLG_N] == 1'b0));
   a_r5_incdec_noflag: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && opcode_i[7:6] == 2'b00 && opcode_i[2:0] == 3'b011) |=> !flag_we_o);
   a_r6_addhl_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && opcode_i[7:6] == 2'b00 && opcode_i[3:0] == 4'h9) |=> (pair_sel_o == PAIR_HL && flag_we_o));

endmodule

// File: tb/rp_arith16_tb_top.sv
`timescale 1ns/100ps
module rp_arith16_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [7:0]  opcode_i = '0;
   logic [7:0]  imm_i = '0;
   logic [15:0] bc_i = '0, de_i = '0, hl_i = '0, sp_i = '0;
   logic [3:0]  flags_i = '0;
   logic        done_o, illegal_o, pair_we_o, flag_we_o;
   logic [1:0]  pair_sel_o, len_o;
   logic [15:0] pair_data_o;
   logic [3:0]  flags_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   rp_arith16 dut_i (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .opcode_i(opcode_i), .imm_i(imm_i),
      .bc_i(bc_i), .de_i(de_i), .hl_i(hl_i), .sp_i(sp_i), .flags_i(flags_i),
      .done_o(done_o), .illegal_o(illegal_o), .pair_we_o(pair_we_o), .pair_sel_o(pair_sel_o),
      .pair_data_o(pair_data_o), .flag_we_o(flag_we_o), .flags_o(flags_o), .len_o(len_o)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   // Expected outputs: {illegal, pair_we, sel, data, len} and {flag_we, flags}
   function automatic void model(input logic [7:0] op, input logic [7:0] imm,
                                 input logic [15:0] bc, de, hl, sp, input logic [3:0] fl,
                                 output logic [21:0] m_exp, output logic [4:0] f_exp,
                                 output string m_tag, output string f_tag, output bit is_ill);
      logic [15:0] p [4];
      logic [16:0] s17;
      logic [12:0] s13;
      logic [8:0]  s9;
      logic [4:0]  s5;
      logic [1:0]  k;
      p[0] = bc; p[1] = de; p[2] = hl; p[3] = sp;
      k = op[5:4];
      is_ill = 1'b0;
      if (op[7:6] == 2'b00 && op[3:0] == 4'h3) begin
         m_exp = {1'b0, 1'b1, k, p[k] + 16'd1, 2'd1};
         f_exp = {1'b0, fl}; m_tag = "R3_inc"; f_tag = "R5_inc_flags";
      end else if (op[7:6] == 2'b00 && op[3:0] == 4'hB) begin
         m_exp = {1'b0, 1'b1, k, p[k] - 16'd1, 2'd1};
         f_exp = {1'b0, fl}; m_tag = "R4_dec"; f_tag = "R5_dec_flags";
      end else if (op[7:6] == 2'b00 && op[3:0] == 4'h9) begin
         s17 = {1'b0, hl} + {1'b0, p[k]};
         s13 = {1'b0, hl[11:0]} + {1'b0, p[k][11:0]};
         m_exp = {1'b0, 1'b1, 2'd2, s17[15:0], 2'd1};
         f_exp = {1'b1, fl[3], 1'b0, s13[12], s17[16]};
         m_tag = "R6_addhl"; f_tag = "R7_addhl_flags";
      end else if (op == 8'hE8) begin
         s9 = {1'b0, sp[7:0]} + {1'b0, imm};
         s5 = {1'b0, sp[3:0]} + {1'b0, imm[3:0]};
         m_exp = {1'b0, 1'b1, 2'd3, sp + {{8{imm[7]}}, imm}, 2'd2};
         f_exp = {1'b1, 1'b0, 1'b0, s5[4], s9[8]};
         m_tag = "R8_addsp"; f_tag = "R9_addsp_flags";
      end else begin
         m_exp = {1'b1, 1'b0, 2'd0, 16'd0, 2'd1};
         f_exp = 5'd0; m_tag = "R10_illegal"; f_tag = "R10_illegal_noflag";
         is_ill = 1'b1;
      end
   endfunction

   task automatic run_op(input logic [7:0] op, input logic [7:0] imm,
                         input logic [15:0] bc, de, hl, sp, input logic [3:0] fl);
      logic [21:0] m_exp, m_got;
      logic [4:0]  f_exp, f_got;
      string mt, ft;
      bit ill;
      model(op, imm, bc, de, hl, sp, fl, m_exp, f_exp, mt, ft, ill);
      @(negedge clk);
      opcode_i = op; imm_i = imm; bc_i = bc; de_i = de; hl_i = hl; sp_i = sp; flags_i = fl;
      issue_i = 1'b1;
      @(negedge clk);
      issue_i = 1'b0;
      opcode_i = $urandom; flags_i = $urandom;
      check("R2_done", {31'd0, done_o}, 32'd1);
      m_got = {illegal_o, pair_we_o, pair_sel_o, pair_data_o, len_o};
      f_got = {flag_we_o, flags_o};
      if (ill) begin
         m_got[19:2] = '0;
         f_got[3:0]  = '0;
      end
      check(mt, {10'd0, m_got}, {10'd0, m_exp});
      check(ft, {27'd0, f_got}, {27'd0, f_exp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] legal [13];
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) begin
         legal[i]     = 8'h03 | 8'(i << 4);
         legal[i + 4] = 8'h0B | 8'(i << 4);
         legal[i + 8] = 8'h09 | 8'(i << 4);
      end
      legal[12] = 8'hE8;

      repeat (3) @(negedge clk);
      check("R1_reset", {22'd0, done_o, illegal_o, pair_we_o, flag_we_o, pair_sel_o, len_o, flags_o},
            32'd0);
      check("R1_reset_data", {16'd0, pair_data_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1_idle", {26'd0, done_o, illegal_o, pair_we_o, flag_we_o, len_o}, 32'd0);

      // directed corners
      run_op(8'h19, 8'h00, 16'h1234, 16'h5678, 16'h9ABC, 16'h0000, 4'b1000); // R7 H only
      run_op(8'h29, 8'h00, 16'h1234, 16'h5678, 16'h9ABC, 16'h0000, 4'b0000); // R7 H and C
      run_op(8'h09, 8'h00, 16'h1234, 16'h5678, 16'h9ABC, 16'h0000, 4'b1111); // R7 neither
      run_op(8'h39, 8'h00, 16'h0000, 16'h0000, 16'hF000, 16'h1000, 4'b0101); // R7 C only
      run_op(8'h3B, 8'h00, 16'h1234, 16'h5678, 16'h9ABC, 16'h0000, 4'b1010); // R4 wrap
      run_op(8'h03, 8'h00, 16'hFFFF, 16'h5678, 16'h9ABC, 16'h0000, 4'b0110); // R3 wrap
      run_op(8'h33, 8'h00, 16'h1234, 16'h5678, 16'h9ABC, 16'hFFFF, 4'b1111); // R3 SP
      run_op(8'hE8, 8'hFF, 16'h0, 16'h0, 16'h0, 16'h1234, 4'b1111);          // R8 negative imm
      run_op(8'hE8, 8'h01, 16'h0, 16'h0, 16'h0, 16'h1234, 4'b1111);          // R9 no carries
      run_op(8'hE8, 8'h80, 16'h0, 16'h0, 16'h0, 16'h00F0, 4'b0000);          // R9 C only
      run_op(8'hE8, 8'h08, 16'h0, 16'h0, 16'h0, 16'h0008, 4'b0000);          // R9 H only
      run_op(8'h00, 8'h00, 16'h1, 16'h2, 16'h3, 16'h4, 4'b1111);             // R10
      run_op(8'hFF, 8'h00, 16'h1, 16'h2, 16'h3, 16'h4, 4'b1111);             // R10

      // R2 pulse width
      @(negedge clk);
      check("R2_pulse", {29'd0, done_o, pair_we_o, flag_we_o}, 32'd0);

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         logic [7:0] op;
         if (($urandom % 5) == 0) op = 8'($urandom);
         else op = legal[$urandom % 13];
         run_op(op, 8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                16'($urandom), 4'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule